// File: doc/BRIEF.md
# Serial LED Shift-Chain Driver

This block turns a 30-bit parallel LED status word into a serial frame for a chain of external 8-bit shift registers with output latches. It drives three lines: a serial clock, a serial data line and an active-high latch strobe. Each frame is 36 serial clock cycles long. It opens with a start bit and two lead pads, carries the 30 LED bits in ascending order, and closes with three tail pads. The data line carries inverted logic, so a lit LED is sent as a low level.

The serial clock is the system clock divided by a parameter. Each serial cycle has a low half followed by a high half. The data line changes only at the start of the low half, so it is stable at the rising edge where the external registers sample it. The LED word is captured at the start of every frame. The latch fires during the low half of the last cycle. While the enable input is high, frames follow one another with no gap. When enable is low, every line rests in its idle level, and the next enable starts a fresh frame from the start bit.

Top module: `led_chain_drv`

## Requirements
- R1: Each serial cycle lasts 2*HALF_DIV system clocks: a low half, then a high half. A frame has exactly 36 rising edges of the serial clock.
- R2: Serial cycle 1 carries the start bit, logical 1, which puts a low level on the data line.
- R3: Serial cycles 2 and 3 carry lead pads of logical 0, which put a high level on the line.
- R4: Serial cycles 4 to 33 carry the LED word. Word bit k (k = 0..29) goes out in cycle k+4, and the line level is the inverse of the bit.
- R5: Serial cycles 34, 35 and 36 carry tail pads of logical 0, which put a high level on the line.
- R6: The latch strobe is high for exactly the HALF_DIV system clocks of the low half of cycle 36, after 35 rising edges of the frame, and is never high while the serial clock is high.
- R7: While in reset, and from the first clock after enable is seen low, the serial clock and latch are low and the data line is high.
- R8: While enable stays high, the next frame's first low half begins right after the high half of cycle 36. The serial clock period is unbroken across the frame boundary.
- R9: The LED word is sampled once, at the start of each frame. A change to the word during a frame has no effect on that frame.
- R10: The frame-done output is high for exactly one system clock: the first clock after the latch strobe falls.
- R11: The data line holds its level for the whole high half of every serial cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable. Low holds the interface idle |
| ledWord | input | LED_W (30) | Parallel LED status word |
| ledSclk | output | 1 | Serial clock to the shift-register chain |
| ledData | output | 1 | Serial data, inverted polarity |
| ledLatch | output | 1 | Active-high strobe that loads the output latches |
| frameDone | output | 1 | One-clock pulse after each latch strobe |

## Verification
The frames are tried with several LED words. Alternating bits catch any off-by-one shift in the data field. All-zero and all-one words show that the inversion applies to data but not to the start bit or pads. Single set bits at each end of the word show where the field starts and ends. Every frame's word is replaced with its complement halfway through, which separates capture at the start of the frame from sampling on the fly. The bench disables the block in mid-frame and then enables it again, to show that the lines go idle and that the next frame restarts cleanly at the start bit.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;

  // Strobes from the sequencer to the frame datapath
  typedef struct packed {
    logic load;   // capture a new word and build the frame
    logic shift;  // advance to the next serial bit
  } ctlStrb_t;

endpackage

// File: rtl/led_chain_ctl.sv
module led_chain_ctl
  import led_chain_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int FRAME_LEN = 36
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     en,
  output ctlStrb_t strb,
  output logic     runQ,
  output logic     sclk,
  output logic     latch,
  output logic     frameDone
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(FRAME_LEN);

  logic [CW-1:0] divCnt;
  logic [BW-1:0] bitIdx;
  logic          phaseHi;
  logic          doneQ;
  logic          endHalf;
  logic          lastBit;

  assign endHalf = (divCnt == CW'(HALF_DIV - 1));
  assign lastBit = (bitIdx == BW'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      divCnt  <= '0;
      bitIdx  <= '0;
      phaseHi <= 1'b0;
      doneQ   <= 1'b0;
    end else if (!en) begin
      runQ    <= 1'b0;
      divCnt  <= '0;
      bitIdx  <= '0;
      phaseHi <= 1'b0;
      doneQ   <= 1'b0;
    end else if (!runQ) begin
      runQ    <= 1'b1;
      divCnt  <= '0;
      bitIdx  <= '0;
      phaseHi <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= endHalf && !phaseHi && lastBit;
      if (endHalf) begin
        divCnt  <= '0;
        phaseHi <= ~phaseHi;
        if (phaseHi) begin
          bitIdx <= lastBit ? '0 : bitIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load  = en && (!runQ || (endHalf && phaseHi && lastBit));
    strb.shift = en && runQ && endHalf && phaseHi && !lastBit;
  end

  assign sclk      = phaseHi;
  assign latch     = runQ && !phaseHi && lastBit;
  assign frameDone = doneQ;

  // R6: latch only during the low half
  p_latch_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    latch |-> !sclk);

  // R7: idle levels one clock after enable is low
  p_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (!sclk && !latch));

  // R10: done is a single-clock pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R10: done follows the falling latch
  p_done_after_latch_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> ($past(latch) && !latch));

endmodule

// File: rtl/led_chain_dp.sv
module led_chain_dp
  import led_chain_pkg::*;
#(
  parameter int LED_W     = 30,
  parameter int LEAD_PAD  = 2,
  parameter int FRAME_LEN = 36
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic             runQ,
  input  logic [LED_W-1:0] ledWord,
  output logic             serData
);

  localparam int DATA_LO = 1 + LEAD_PAD;

  logic [FRAME_LEN-1:0] frameSr;

  // Logical frame, bit k goes out in serial cycle k+1
  function automatic logic [FRAME_LEN-1:0] buildFrame(input logic [LED_W-1:0] w);
    logic [FRAME_LEN-1:0] f;
    f = '0;
    f[0] = 1'b1;
    for (int i = 0; i < LED_W; i++) begin
      f[DATA_LO + i] = w[i];
    end
    return f;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr <= '0;
    end else if (strb.load) begin
      frameSr <= buildFrame(ledWord);
    end else if (strb.shift) begin
      frameSr <= {1'b0, frameSr[FRAME_LEN-1:1]};
    end
  end

  assign serData = runQ ? ~frameSr[0] : 1'b1;

  // R5: a shift always fills the top with a logical-0 pad
  p_tail_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.shift) |-> (frameSr[FRAME_LEN-1] == 1'b0));

endmodule

// File: rtl/led_chain_drv.sv
module led_chain_drv
  import led_chain_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int LED_W    = 30,
  parameter int LEAD_PAD = 2,
  parameter int TAIL_PAD = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [LED_W-1:0] ledWord,
  output logic             ledSclk,
  output logic             ledData,
  output logic             ledLatch,
  output logic             frameDone
);

  localparam int FRAME_LEN = 1 + LEAD_PAD + LED_W + TAIL_PAD;

  ctlStrb_t strb;
  logic     runQ;

  led_chain_ctl #(
    .HALF_DIV (HALF_DIV),
    .FRAME_LEN(FRAME_LEN)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .en       (en),
    .strb     (strb),
    .runQ     (runQ),
    .sclk     (ledSclk),
    .latch    (ledLatch),
    .frameDone(frameDone)
  );

  led_chain_dp #(
    .LED_W    (LED_W),
    .LEAD_PAD (LEAD_PAD),
    .FRAME_LEN(FRAME_LEN)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .runQ   (runQ),
    .ledWord(ledWord),
    .serData(ledData)
  );

  // R11: data holds through the high half
  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ledSclk && $past(ledSclk)) |-> $stable(ledData));

endmodule

// File: tb/test_led_chain_drv.sv
module test_led_chain_drv;

  localparam int HALF_DIV = 4;
  localparam int LED_W    = 30;
  localparam int NBITS    = 36;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             en = 1'b0;
  logic [LED_W-1:0] ledWord = '0;
  logic             ledSclk, ledData, ledLatch, frameDone;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  led_chain_drv #(.HALF_DIV(HALF_DIV), .LED_W(LED_W)) i_led_chain_drv (
    .clk(clk), .rstN(rstN), .en(en), .ledWord(ledWord),
    .ledSclk(ledSclk), .ledData(ledData), .ledLatch(ledLatch), .frameDone(frameDone)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Line levels expected for cycles 1..36 (index k = cycle k+1)
  function automatic logic [NBITS-1:0] expLine(input logic [LED_W-1:0] w);
    logic [NBITS-1:0] l;
    l = '1;
    l[0] = 1'b0;                                             // R2 start bit
    for (int i = 0; i < LED_W; i++) l[3 + i] = ~w[i];        // R4 data inverted
    return l;
  endfunction

  logic [NBITS-1:0] expQ[$];

  // Monitor
  int   riseCnt = 0, latchCnt = 0, sinceRise = 0;
  bit   prevSclk = 0, prevLatch = 0, havePeriod = 0;
  logic [NBITS-1:0] got;

  always @(negedge clk) begin
    if (!rstN || !en) begin
      riseCnt = 0; latchCnt = 0; sinceRise = 0;
      prevSclk = 0; prevLatch = 0; havePeriod = 0;
    end else begin
      sinceRise++;
      if (ledSclk && !prevSclk) begin
        if (havePeriod)
          check(sinceRise == 2*HALF_DIV, "R1/R8 serial period", sinceRise, 2*HALF_DIV);
        havePeriod = 1;
        sinceRise = 0;
        if (riseCnt < NBITS) got[riseCnt] = ledData;
        riseCnt++;
      end
      if (ledLatch) begin
        latchCnt++;
        check(!ledSclk && riseCnt == NBITS-1, "R6 latch position", riseCnt, NBITS-1);
      end
      if (frameDone) begin
        logic [NBITS-1:0] e;
        check(prevLatch && !ledLatch, "R10 done after latch", {prevLatch, ledLatch}, 2'b10);
        check(riseCnt == NBITS, "R1 rises per frame", riseCnt, NBITS);
        check(latchCnt == HALF_DIV, "R6 latch width", latchCnt, HALF_DIV);
        if (expQ.size() == 0) begin
          check(0, "R9 unexpected frame", 0, 1);
        end else begin
          e = expQ.pop_front();
          check(got[0] == e[0], "R2 start bit", got[0], e[0]);
          check(got[2:1] == e[2:1], "R3 lead pads", got[2:1], e[2:1]);
          check(got[32:3] == e[32:3], "R4/R9 data field", got[32:3], e[32:3]);
          check(got[35:33] == e[35:33], "R5 tail pads", got[35:33], e[35:33]);
        end
        riseCnt = 0; latchCnt = 0;
      end
      prevSclk = ledSclk;
      prevLatch = ledLatch;
    end
  end

  task automatic checkIdle(input string req);
    @(negedge clk);
    check(!ledSclk && !ledLatch && ledData && !frameDone, req,
          {ledSclk, ledLatch, ledData, frameDone}, 4'b0010);
  endtask

  // Driver: after a frame ends, queue the next word, then scramble it mid-frame
  task automatic nextFrame(input logic [LED_W-1:0] w);
    wait (frameDone);
    #2 ledWord = w;
    expQ.push_back(expLine(w));
    repeat (100) @(posedge clk);
    #2 ledWord = ~w;  // R9 mid-frame change
  endtask

  initial begin
    repeat (5) @(posedge clk);
    checkIdle("R7 idle in reset");
    #2 rstN = 1'b1;
    repeat (10) @(posedge clk);
    checkIdle("R7 idle while disabled");

    @(posedge clk);
    #2 ledWord = 30'h15555555;
    expQ.push_back(expLine(ledWord));
    en = 1'b1;
    repeat (100) @(posedge clk);
    #2 ledWord = ~ledWord;

    nextFrame(30'h00000000);
    nextFrame(30'h3FFFFFFF);
    nextFrame(30'h00000001);
    nextFrame(30'h20000000);
    nextFrame(30'h0F0F0F0F);
    nextFrame(30'h2AAAAAAA);

    // Disable in mid-frame
    wait (frameDone);
    repeat (50) @(posedge clk);
    #2 en = 1'b0;
    expQ.delete();
    @(posedge clk);
    repeat (8) checkIdle("R7 idle after disable");

    // Re-enable: the frame restarts from the start bit
    @(posedge clk);
    #2 ledWord = 30'h12345678;
    expQ.push_back(expLine(ledWord));
    en = 1'b1;
    wait (frameDone);
    @(negedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R8 restart frame consumed", expQ.size(), 0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule